// File: doc/BRIEF.md
# Bus Address Region Decoder

This block sits between a CPU core and its memory system. It takes one byte-addressed access at a time and steers it to a boot ROM, a RAM or an external device port. The address is 24 bits wide. Each access is a byte, a word or a long. A long is broken into two aligned word beats. Big-endian words and longs are assembled from the 16-bit data each target returns.

The first eight bytes of the address space are a read-only view of the start of ROM, so the reset vectors come from ROM. A second ROM window sits just below the device space. Every address from 0x800000 up goes to the device port. The RAM size is a parameter. A RAM read past that size returns all-ones, and a RAM write past it is dropped.

The ROM, the RAM and the device model live outside the block. Each of them returns the 16-bit word that contains the presented offset in the same cycle.

Top module: `addr_route_unit`

## Requirements
- R1: A read at an address below 0x000008 selects ROM (`rom_sel`) with target offset equal to the address.
- R2: An address from 0x000008 up to but not including 0x7E0000 that is below `RAM_BYTES` selects RAM (`ram_sel`), for reads and writes, with offset equal to the address. Written data reads back unchanged.
- R3: A read from 0x7E0000 up to but not including 0x800000 selects ROM with offset equal to the address minus 0x7E0000.
- R4: An address at or above 0x800000 selects the device port (`dev_sel`), for reads and writes, with offset equal to the address.
- R5: A write into either ROM window, including the low eight bytes, asserts no select and has no effect on the contents that a later read returns.
- R6: In the RAM range, an address at or above `RAM_BYTES` asserts no select. A read there returns 0xFF in every byte, and a write there is discarded.
- R7: Size codes are 0 for a byte, 1 for a word, 2 for a long, and 3 behaves as a word. Data is big-endian: the byte at A goes in bits 15:8 of a word and the byte at A+1 in bits 7:0. A byte read returns its value in `rsp_rdata[7:0]` with the upper bits zero. A word read returns its value in `rsp_rdata[15:0]`.
- R8: A long is performed as a word beat at A, then a word beat at A+2. A long read returns {word(A), word(A+2)}. `busy` is high during both beats.
- R9: A word or long request at an odd address pulses `rsp_done` and `rsp_err` one cycle after the request, asserts no select and transfers nothing.
- R10: Latency is counted from the request edge to the `rsp_done` cycle:
  - byte and word writes: 1 cycle;
  - long writes: 2 cycles;
  - byte and word reads: 2 cycles;
  - long reads: 3 cycles.
- R11: A request presented while `busy` is high is ignored.
- R12: After reset there are no selects, and `busy`, `rsp_done`, `rsp_err` and `rsp_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request, taken when not busy |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 0 byte, 1 word, 2 long, 3 word |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, right-aligned |
| rom_sel | output | 1 | ROM read beat |
| ram_sel | output | 1 | RAM beat |
| dev_sel | output | 1 | Device port beat |
| tgt_we | output | 1 | Beat is a write |
| tgt_byte | output | 1 | Beat is a single byte |
| tgt_off | output | ADDR_W | Translated byte offset in the target |
| tgt_wdata | output | 16 | Beat write data (a byte is replicated in both lanes) |
| rom_rdata | input | 16 | ROM word containing the offset |
| ram_rdata | input | 16 | RAM word containing the offset |
| dev_rdata | input | 16 | Device word containing the offset |
| rsp_done | output | 1 | Access complete pulse |
| rsp_err | output | 1 | Misaligned access pulse, together with done |
| rsp_rdata | output | 32 | Read result, held until the next read |
| busy | output | 1 | A beat is in progress; new requests are ignored |

## Verification
The bench issues random addresses weighted over five areas:
- the low alias;
- populated RAM;
- RAM past its populated size;
- the high ROM window;
- the device space.

Each access has a random size, direction and alignment, so a wrong region choice, a wrong offset or a missing fill value shows up as a different select, offset or read value.

Directed cases cover the region boundaries. Two long accesses straddle a boundary: one from the low alias into RAM, and one from RAM past its size into the high ROM window. These expose beats that are decoded together instead of one by one.

A write to each ROM window followed by a read-back separates a dropped write from a stored one. An odd-address word and an odd-address long separate the error path from a normal transfer. A request made in the middle of a long shows whether requests are really ignored while busy.

// File: rtl/addr_route_pkg.sv
package addr_route_pkg;

    // request size encoding; code 3 is handled like a word
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        RG_LOW_ROM  = 2'd0,
        RG_RAM      = 2'd1,
        RG_HIGH_ROM = 2'd2,
        RG_DEVICE   = 2'd3
    } region_e;

endpackage

// File: rtl/addr_route_region.sv
module addr_route_region
    import addr_route_pkg::*;
#(
    parameter int unsigned ADDR_W      = 24,
    parameter int unsigned RAM_BYTES   = 4096,
    parameter int unsigned ALIAS_BYTES = 8,
    parameter int unsigned HIROM_BASE  = 32'h007E_0000,
    parameter int unsigned DEV_BASE    = 32'h0080_0000
) (
    input  logic [ADDR_W-1:0] beat_addr,
    input  logic              beat_write,
    input  logic              beat_active,
    output region_e           region,
    output logic [ADDR_W-1:0] offset,
    output logic              rom_sel,
    output logic              ram_sel,
    output logic              dev_sel,
    output logic              fill
);

    localparam logic [ADDR_W:0] ALIAS_END = (ADDR_W+1)'(ALIAS_BYTES);
    localparam logic [ADDR_W:0] HI_START  = (ADDR_W+1)'(HIROM_BASE);
    localparam logic [ADDR_W:0] DEV_START = (ADDR_W+1)'(DEV_BASE);
    localparam logic [ADDR_W:0] RAM_END   = (ADDR_W+1)'(RAM_BYTES);

    logic [ADDR_W:0] ext_addr;
    logic            ram_fit;

    assign ext_addr = {1'b0, beat_addr};
    assign ram_fit  = (ext_addr < RAM_END);

    always_comb begin
        if (ext_addr < ALIAS_END) begin
            region = RG_LOW_ROM;
        end else if (ext_addr < HI_START) begin
            region = RG_RAM;
        end else if (ext_addr < DEV_START) begin
            region = RG_HIGH_ROM;
        end else begin
            region = RG_DEVICE;
        end
    end

    always_comb begin
        if (region == RG_HIGH_ROM) begin
            offset = beat_addr - HI_START[ADDR_W-1:0];
        end else begin
            offset = beat_addr;
        end
    end

    // ROM is only ever read; writes to either ROM window are dropped
    assign rom_sel = beat_active && !beat_write &&
                     (region == RG_LOW_ROM || region == RG_HIGH_ROM);
    assign ram_sel = beat_active && (region == RG_RAM) && ram_fit;
    assign dev_sel = beat_active && (region == RG_DEVICE);
    assign fill    = (region == RG_RAM) && !ram_fit;

endmodule

// File: rtl/addr_route_lane.sv
module addr_route_lane
    import addr_route_pkg::*;
(
    input  region_e     region,
    input  logic        fill,
    input  logic        lane_lo,
    input  logic [15:0] rom_rdata,
    input  logic [15:0] ram_rdata,
    input  logic [15:0] dev_rdata,
    output logic [15:0] beat_word,
    output logic [7:0]  beat_byte
);

    always_comb begin
        case (region)
            RG_LOW_ROM, RG_HIGH_ROM: beat_word = rom_rdata;
            RG_RAM:                  beat_word = fill ? 16'hFFFF : ram_rdata;
            default:                 beat_word = dev_rdata;
        endcase
    end

    // big-endian lanes: even byte in the upper half
    assign beat_byte = lane_lo ? beat_word[7:0] : beat_word[15:8];

endmodule

// File: rtl/addr_route_unit.sv
module addr_route_unit
    import addr_route_pkg::*;
#(
    parameter int unsigned ADDR_W      = 24,
    parameter int unsigned RAM_BYTES   = 4096,
    parameter int unsigned ALIAS_BYTES = 8,
    parameter int unsigned HIROM_BASE  = 32'h007E_0000,
    parameter int unsigned DEV_BASE    = 32'h0080_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    output logic              rom_sel,
    output logic              ram_sel,
    output logic              dev_sel,
    output logic              tgt_we,
    output logic              tgt_byte,
    output logic [ADDR_W-1:0] tgt_off,
    output logic [15:0]       tgt_wdata,
    input  logic [15:0]       rom_rdata,
    input  logic [15:0]       ram_rdata,
    input  logic [15:0]       dev_rdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              busy
);

    localparam logic [ADDR_W-1:0] BEAT_STEP = ADDR_W'(2);
    localparam logic [ADDR_W:0]   RAM_END   = (ADDR_W+1)'(RAM_BYTES);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        xfer_size_e        sz;
        logic [31:0]       wdata;
        logic [15:0]       upper;
        logic [31:0]       rdata;
        logic              done;
        logic              err;
    } state_t;

    state_t st_d, st_q;

    region_e     beat_region;
    logic        beat_fill;
    logic [15:0] beat_word;
    logic [7:0]  beat_byte;
    logic        beat_active;
    logic        is_long;
    logic        is_byte;
    logic        misalign;
    logic        write_last;

    assign beat_active = (st_q.phase != PH_IDLE);
    assign is_long     = (st_q.sz == SZ_LONG);
    assign is_byte     = (st_q.sz == SZ_BYTE);
    assign misalign    = req_addr[0] && (xfer_size_e'(req_size) != SZ_BYTE);

    addr_route_region #(
        .ADDR_W      (ADDR_W),
        .RAM_BYTES   (RAM_BYTES),
        .ALIAS_BYTES (ALIAS_BYTES),
        .HIROM_BASE  (HIROM_BASE),
        .DEV_BASE    (DEV_BASE)
    ) u_region (
        .beat_addr   (st_q.addr),
        .beat_write  (st_q.wr),
        .beat_active (beat_active),
        .region      (beat_region),
        .offset      (tgt_off),
        .rom_sel     (rom_sel),
        .ram_sel     (ram_sel),
        .dev_sel     (dev_sel),
        .fill        (beat_fill)
    );

    addr_route_lane u_lane (
        .region    (beat_region),
        .fill      (beat_fill),
        .lane_lo   (st_q.addr[0]),
        .rom_rdata (rom_rdata),
        .ram_rdata (ram_rdata),
        .dev_rdata (dev_rdata),
        .beat_word (beat_word),
        .beat_byte (beat_byte)
    );

    // next-state computation
    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    if (misalign) begin
                        st_d.done  = 1'b1;
                        st_d.err   = 1'b1;
                        st_d.rdata = '0;
                    end else begin
                        st_d.phase = PH_FIRST;
                        st_d.addr  = req_addr;
                        st_d.wr    = req_write;
                        st_d.sz    = xfer_size_e'(req_size);
                        st_d.wdata = req_wdata;
                    end
                end
            end
            PH_FIRST: begin
                if (is_long) begin
                    st_d.upper = beat_word;
                    st_d.addr  = st_q.addr + BEAT_STEP;
                    st_d.phase = PH_SECOND;
                end else begin
                    st_d.phase = PH_IDLE;
                    if (!st_q.wr) begin
                        st_d.done  = 1'b1;
                        st_d.rdata = is_byte ? {24'h0, beat_byte} : {16'h0, beat_word};
                    end
                end
            end
            PH_SECOND: begin
                st_d.phase = PH_IDLE;
                if (!st_q.wr) begin
                    st_d.done  = 1'b1;
                    st_d.rdata = {st_q.upper, beat_word};
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // beat data and response outputs
    always_comb begin
        if (is_byte) begin
            tgt_wdata = {st_q.wdata[7:0], st_q.wdata[7:0]};
        end else if (is_long && st_q.phase == PH_FIRST) begin
            tgt_wdata = st_q.wdata[31:16];
        end else begin
            tgt_wdata = st_q.wdata[15:0];
        end
    end

    assign write_last = st_q.wr &&
                        ((st_q.phase == PH_FIRST && !is_long) || st_q.phase == PH_SECOND);
    assign tgt_we     = beat_active && st_q.wr;
    assign tgt_byte   = beat_active && is_byte;
    assign rsp_done   = st_q.done || write_last;
    assign rsp_err    = st_q.err;
    assign rsp_rdata  = st_q.rdata;
    assign busy       = beat_active;

    // checks on the beat outputs
    p_single_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_sel, ram_sel, dev_sel}));

    p_rom_read_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> !tgt_we);

    p_ram_in_bounds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sel |-> ({1'b0, tgt_off} < RAM_END));

    p_second_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_FIRST && is_long) |=>
            (busy && st_q.addr == $past(st_q.addr) + BEAT_STEP));

    p_error_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_done && !busy && !rom_sel && !ram_sel && !dev_sel));

    p_ignore_when_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid && st_q.phase == PH_SECOND) |=> !busy);

endmodule

// File: tb/addr_route_unit_test.sv
module addr_route_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int RAM_B      = 1024;
    localparam int ROM_B      = 256;
    localparam int DEV_B      = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rom_sel, ram_sel, dev_sel, tgt_we, tgt_byte;
    logic [23:0] tgt_off;
    logic [15:0] tgt_wdata, rom_rdata, ram_rdata, dev_rdata;
    logic        rsp_done, rsp_err, busy;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;

    logic [7:0] rom_m [ROM_B];
    logic [7:0] ram_m [RAM_B];
    logic [7:0] dev_m [DEV_B];
    logic [7:0] ref_rom [ROM_B];
    logic [7:0] ref_ram [RAM_B];
    logic [7:0] ref_dev [DEV_B];

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_route_unit #(.RAM_BYTES(RAM_B)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .rom_sel(rom_sel), .ram_sel(ram_sel), .dev_sel(dev_sel), .tgt_we(tgt_we),
        .tgt_byte(tgt_byte), .tgt_off(tgt_off), .tgt_wdata(tgt_wdata),
        .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .dev_rdata(dev_rdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .busy(busy)
    );

    // target models: return the word containing the offset
    assign rom_rdata = {rom_m[{tgt_off[7:1], 1'b0}], rom_m[{tgt_off[7:1], 1'b1}]};
    assign ram_rdata = {ram_m[{tgt_off[9:1], 1'b0}], ram_m[{tgt_off[9:1], 1'b1}]};
    assign dev_rdata = {dev_m[{tgt_off[7:1], 1'b0}], dev_m[{tgt_off[7:1], 1'b1}]};

    always @(posedge clk) begin
        if (ram_sel && tgt_we) begin
            if (tgt_byte) ram_m[tgt_off[9:0]] <= tgt_wdata[7:0];
            else begin
                ram_m[{tgt_off[9:1], 1'b0}] <= tgt_wdata[15:8];
                ram_m[{tgt_off[9:1], 1'b1}] <= tgt_wdata[7:0];
            end
        end
        if (dev_sel && tgt_we) begin
            if (tgt_byte) dev_m[tgt_off[7:0]] <= tgt_wdata[7:0];
            else begin
                dev_m[{tgt_off[7:1], 1'b0}] <= tgt_wdata[15:8];
                dev_m[{tgt_off[7:1], 1'b1}] <= tgt_wdata[7:0];
            end
        end
    end

    function automatic logic [7:0] exp_byte(input logic [23:0] a);
        if (a < 24'h8)           return ref_rom[a[7:0]];
        else if (a < 24'h7E0000) return (a < RAM_B) ? ref_ram[a[9:0]] : 8'hFF;
        else if (a < 24'h800000) return ref_rom[8'(a - 24'h7E0000)];
        else                     return ref_dev[a[7:0]];
    endfunction

    function automatic void ref_write(input logic [23:0] a, input logic [7:0] b);
        if (a >= 24'h8 && a < 24'h7E0000 && a < RAM_B) ref_ram[a[9:0]] = b;
        else if (a >= 24'h800000) ref_dev[a[7:0]] = b;
    endfunction

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd2) ? 4 : 2;
    endfunction

    function automatic string rtag(input logic [23:0] a);
        if (a < 24'h8)           return "R1";
        else if (a < 24'h7E0000) return (a < RAM_B) ? "R2" : "R6";
        else if (a < 24'h800000) return "R3";
        else                     return "R4";
    endfunction

    // expected first-beat target: 0 none, 1 ROM, 2 RAM, 3 device
    function automatic int exp_target(input logic [23:0] a, input logic wr);
        if (a < 24'h8 || (a >= 24'h7E0000 && a < 24'h800000)) return wr ? 0 : 1;
        else if (a < 24'h7E0000) return (a < RAM_B) ? 2 : 0;
        else                     return 3;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic [23:0] a, input logic [1:0] sz, input logic wr,
                          input logic [31:0] wd, input string force_tag);
        int          n, k, lat, tgt1;
        bit          got, odd, err_seen, busy1, busy2;
        logic [31:0] expv, rd;
        logic [23:0] off1, exp_off;
        string       tag;
        n    = nbytes(sz);
        odd  = a[0] && (sz != 2'd0);
        tag  = (force_tag != "") ? force_tag : rtag(a);
        expv = '0;
        for (int i = 0; i < n; i++) expv = {expv[23:0], exp_byte(a + 24'(i))};
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        k = 1; got = 0; tgt1 = 0; off1 = '0; busy1 = 0; busy2 = 0;
        rd = '0; err_seen = 0;
        while (!got && k < 8) begin
            if (k == 1) begin
                tgt1  = rom_sel ? 1 : ram_sel ? 2 : dev_sel ? 3 : 0;
                off1  = tgt_off;
                busy1 = busy;
            end
            if (k == 2) busy2 = busy;
            if (rsp_done) begin
                got = 1; rd = rsp_rdata; err_seen = rsp_err;
            end else begin
                @(negedge clk);
                k++;
            end
        end
        lat = odd ? 1 : wr ? ((sz == 2'd2) ? 2 : 1) : ((sz == 2'd2) ? 3 : 2);
        chk(got && k == lat, "R10", "latency", 32'(k), 32'(lat));
        if (odd) begin
            chk(err_seen, "R9", "error flag", 32'(err_seen), 32'd1);
            chk(tgt1 == 0, "R9", "select on misaligned", 32'(tgt1), 32'd0);
        end else begin
            chk(!err_seen, tag, "spurious error", 32'(err_seen), 32'd0);
            chk(tgt1 == exp_target(a, wr), wr ? ((tgt1 != 0 && exp_target(a, 1'b0) == 1) ? "R5" : tag) : tag,
                "first beat target", 32'(tgt1), 32'(exp_target(a, wr)));
            exp_off = (a >= 24'h7E0000 && a < 24'h800000) ? a - 24'h7E0000 : a;
            if (tgt1 != 0) chk(off1 == exp_off, tag, "offset", 32'(off1), 32'(exp_off));
            if (sz == 2'd2)
                chk(busy1 && busy2, "R8", "busy over both beats", {busy1, busy2}, 32'd3);
            if (!wr) chk(rd == expv, (sz == 2'd2) ? "R8" : tag, "read data", rd, expv);
            else for (int i = 0; i < n; i++) ref_write(a + 24'(i), wd[8*(n-1-i) +: 8]);
        end
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog actual=hang expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [23:0] a;
        logic [1:0]  sz;
        void'($urandom(32'd20210407));
        for (int i = 0; i < ROM_B; i++) begin rom_m[i] = 8'(i * 7 + 3); ref_rom[i] = rom_m[i]; end
        for (int i = 0; i < RAM_B; i++) begin ram_m[i] = 8'(i) ^ 8'h5A; ref_ram[i] = ram_m[i]; end
        for (int i = 0; i < DEV_B; i++) begin dev_m[i] = 8'(i + 8'h80); ref_dev[i] = dev_m[i]; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(!rom_sel && !ram_sel && !dev_sel, "R12", "selects after reset",
            {rom_sel, ram_sel, dev_sel}, 32'd0);
        chk(!busy && !rsp_done && !rsp_err, "R12", "flags after reset",
            {busy, rsp_done, rsp_err}, 32'd0);
        chk(rsp_rdata == 32'h0, "R12", "read data after reset", rsp_rdata, 32'h0);

        // directed corners
        access(24'h000000, 2'd2, 1'b0, '0, "");             // R1 reset vector long
        access(24'h000003, 2'd0, 1'b0, '0, "R7");           // odd byte lane
        access(24'h000004, 2'd1, 1'b1, 32'h0000BEEF, "R5"); // write to low alias
        access(24'h000004, 2'd1, 1'b0, '0, "R5");
        access(24'h000006, 2'd2, 1'b1, 32'h11223344, "");   // straddles alias into RAM
        access(24'h000006, 2'd2, 1'b0, '0, "R8");
        access(24'h000100, 2'd3, 1'b1, 32'h0000A1B2, "R7"); // size code 3 as word
        access(24'h000100, 2'd0, 1'b0, '0, "R7");
        access(24'h000101, 2'd0, 1'b0, '0, "R7");
        access(24'h7E0010, 2'd1, 1'b1, 32'h00005555, "R5"); // write high ROM
        access(24'h7E0010, 2'd1, 1'b0, '0, "R3");
        access(24'(RAM_B), 2'd1, 1'b1, 32'h00001234, "R6");
        access(24'(RAM_B), 2'd1, 1'b0, '0, "R6");
        access(24'h7DFFFE, 2'd2, 1'b0, '0, "R8");           // fill then high ROM
        access(24'h000203, 2'd1, 1'b0, '0, "R9");
        access(24'h800011, 2'd2, 1'b1, 32'hFFFFFFFF, "R9");
        access(24'h800020, 2'd2, 1'b1, 32'hCAFEF00D, "R4");
        access(24'h800020, 2'd2, 1'b0, '0, "R4");

        // R11: request during a long is ignored
        @(negedge clk);
        req_valid = 1'b1; req_addr = 24'h000300; req_size = 2'd2; req_write = 1'b0;
        @(negedge clk);
        req_addr = 24'h000200; req_size = 2'd1; req_write = 1'b1; req_wdata = 32'h0000DEAD;
        chk(busy, "R11", "busy during long", 32'(busy), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        while (busy || rsp_done) @(negedge clk);
        access(24'h000200, 2'd1, 1'b0, '0, "R11");

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            case ($urandom % 5)
                0: a = 24'($urandom % 8);
                1: a = 24'(8 + $urandom % (RAM_B - 8));
                2: a = 24'(RAM_B + $urandom % 4096);
                3: a = 24'h7E0000 + 24'($urandom % 24'h1FFF0);
                default: a = 24'h800000 + 24'($urandom % 24'h7FFF00);
            endcase
            sz = 2'($urandom % 4);
            if (($urandom % 8) != 0 && sz != 2'd0) a[0] = 1'b0;
            access(a, sz, 1'($urandom % 2), $urandom, "");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule